// File: doc/BRIEF.md
# Legacy System Control Register

This block is a byte-wide read/write control and status register for the legacy system-control I/O location of a PC-compatible chipset. Software uses its low four bits to drive the gate input of interval timer channel 2, to pass that channel's output to the speaker, and to enable or disable non-maskable interrupt reporting for two error sources. The upper four bits are read-only. They show two sticky error flags, the live level of timer channel 2, and a bit that flips each time timer channel 1 falls.

The error sources are a combined bus parity/system error input (active high) and an I/O channel check input (active low). Each error latches into its flag only while the matching enable bit is 0. The flag stays set until software writes 1 to that enable bit. The block asserts an NMI request while either flag is set. All asynchronous inputs pass through a two-flop synchronizer, so a change on an input shows at the register two clock edges later. The timers and the NMI routing belong to other blocks.

Top module: `sysctl_portb_reg`

## Requirements
- R1: After reset the read value is 8'b0000_1100 while the timer-2 input is low, and `nmi_req`, `tmr2_gate` and `spkr_out` are 0.
- R2: A write stores `wr_data[3:0]` into bits 3..0 on the next edge. Written values of bits 7..4 have no effect on the read value.
- R3: `tmr2_gate` equals stored bit 0.
- R4: `spkr_out` is the AND of stored bit 1 and the synchronized timer-2 level.
- R5: Read bit 5 shows the timer-2 input level, at most three edges after the input changes.
- R6: Read bit 4 inverts once for each falling edge of the timer-1 input. A rising edge does not change it.
- R7: Read bit 7 sets when the bus error input is high while bit 2 is 0. It stays set after the input returns low. It never sets while bit 2 is 1.
- R8: Read bit 6 sets when the channel-check input is low while bit 3 is 0. It stays set after the input returns high. It never sets while bit 3 is 1.
- R9: A write with bit 2 = 1 clears bit 7, and a write with bit 3 = 1 clears bit 6. Writing 0 to either enable bit leaves the flags unchanged.
- R10: `nmi_req` is high exactly when read bit 7 or read bit 6 is set, and it drops when both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register read value |
| bus_err | input | 1 | Asynchronous parity/system error, active high |
| chan_chk_n | input | 1 | Asynchronous I/O channel check, active low |
| tmr1_out | input | 1 | Asynchronous timer channel 1 output |
| tmr2_out | input | 1 | Asynchronous timer channel 2 output |
| tmr2_gate | output | 1 | Gate drive for timer channel 2 |
| spkr_out | output | 1 | Gated speaker drive |
| nmi_req | output | 1 | NMI request from latched errors |

## Verification
The assertions assume that `wr_en` and `wr_data` are clean synchronous signals that are low during reset. They also assume that the asynchronous inputs are only ever seen through the synchronizer, so no property refers to raw input levels. The stimulus drives every input a short time after a rising edge. It holds each error or timer level for at least four edges before it checks a result, so that every flag and toggle has settled through the two-flop delay and the latch stage.

// File: rtl/sysctl_portb_reg.sv
module sysctl_portb_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       bus_err,
  input  logic       chan_chk_n,
  input  logic       tmr1_out,
  input  logic       tmr2_out,
  output logic       tmr2_gate,
  output logic       spkr_out,
  output logic       nmi_req
);

  localparam logic [3:0] CTRL_RST = 4'b1100;
  localparam logic [3:0] SYNC_RST = 4'b0010;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] in_s;
  logic [3:0] ctrl;
  logic       tmr1_d, flip;
  logic       par_sts, chk_sts;
  logic       bus_err_s, chk_n_s, tmr1_s, tmr2_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= {tmr2_out, tmr1_out, chan_chk_n, bus_err};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign in_s      = sync_q[SYNC_STAGES-1];
  assign bus_err_s = in_s[0];
  assign chk_n_s   = in_s[1];
  assign tmr1_s    = in_s[2];
  assign tmr2_s    = in_s[3];

  wire clr_par = wr_en && wr_data[2];
  wire clr_chk = wr_en && wr_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      tmr1_d  <= 1'b0;
      flip    <= 1'b0;
      par_sts <= 1'b0;
      chk_sts <= 1'b0;
    end else begin
      tmr1_d <= tmr1_s;
      if (tmr1_d && !tmr1_s) flip <= ~flip;
      if (wr_en) ctrl <= wr_data[3:0];
      if (clr_par)                      par_sts <= 1'b0;
      else if (!ctrl[2] && bus_err_s)   par_sts <= 1'b1;
      if (clr_chk)                      chk_sts <= 1'b0;
      else if (!ctrl[3] && !chk_n_s)    chk_sts <= 1'b1;
    end
  end

  assign rd_data   = {par_sts, chk_sts, tmr2_s, flip, ctrl};
  assign tmr2_gate = ctrl[0];
  assign spkr_out  = ctrl[1] & tmr2_s;
  assign nmi_req   = (par_sts & ~ctrl[2]) | (chk_sts & ~ctrl[3]);

endmodule

// File: rtl/sysctl_portb_reg_chk.sv
module sysctl_portb_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tmr2_gate,
  input logic       spkr_out,
  input logic       nmi_req
);

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[3:0]));

  // R3
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tmr2_gate == $past(wr_data[0]));

  // R4
  spkr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spkr_out |-> (rd_data[1] && rd_data[5]));

  // R7
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && wr_data[2])) |=> rd_data[7]);

  // R8
  chk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && !(wr_en && wr_data[3])) |=> rd_data[6]);

  // R9
  par_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2]) |=> !rd_data[7]);

  // R9
  chk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> !rd_data[6]);

  // R10
  nmi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (rd_data[7] || rd_data[6]));

endmodule

bind sysctl_portb_reg sysctl_portb_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tmr2_gate(tmr2_gate), .spkr_out(spkr_out),
  .nmi_req(nmi_req)
);

// File: tb/sysctl_portb_reg_bench.sv
module sysctl_portb_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       bus_err = 1'b0, chan_chk_n = 1'b1, tmr1_out = 1'b0, tmr2_out = 1'b0;
  logic       tmr2_gate, spkr_out, nmi_req;
  int checks = 0, fails = 0;
  logic exp_tog = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_portb_reg u_sysctl_portb_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_err(bus_err), .chan_chk_n(chan_chk_n), .tmr1_out(tmr1_out), .tmr2_out(tmr2_out),
    .tmr2_gate(tmr2_gate), .spkr_out(spkr_out), .nmi_req(nmi_req)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk("R1 rd", rd_data, 8'h0C);
    chk("R1 outs", {nmi_req, tmr2_gate, spkr_out}, 3'b000);

    for (int v = 0; v < 16; v++) begin
      for (int t = 0; t < 2; t++) begin
        tmr2_out = t[0];
        wr(8'hF0 | 8'(v));
        tick(3);
        // R2 R5
        chk("R2/R5 rd", rd_data, {2'b00, t[0], 1'b0, 4'(v)});
        // R3
        chk("R3 gate", tmr2_gate, v[0]);
        // R4
        chk("R4 spkr", spkr_out, v[1] & t[0]);
      end
    end
    tmr2_out = 1'b0;

    wr(8'h0C);
    for (int k = 0; k < 5; k++) begin
      tmr1_out = 1'b1; tick(4);
      // R6 rising edge: no change
      chk("R6 rise", rd_data[4], exp_tog);
      tmr1_out = 1'b0; tick(4);
      exp_tog = ~exp_tog;
      // R6 falling edge flips
      chk("R6 fall", rd_data[4], exp_tog);
    end

    wr(8'h08);
    bus_err = 1'b1; tick(4);
    // R7
    chk("R7 set", rd_data[7], 1'b1);
    // R10
    chk("R10 nmi par", nmi_req, 1'b1);
    bus_err = 1'b0; tick(4);
    chk("R7 sticky", rd_data[7], 1'b1);
    wr(8'h08);
    // R9 write 0 keeps flag
    chk("R9 keep", rd_data[7], 1'b1);
    wr(8'h0C);
    // R9
    chk("R9 clr7", rd_data[7], 1'b0);
    chk("R10 drop", nmi_req, 1'b0);
    bus_err = 1'b1; tick(4);
    // R7 masked
    chk("R7 masked", {rd_data[7], nmi_req}, 2'b00);
    bus_err = 1'b0; tick(4);

    wr(8'h04);
    chan_chk_n = 1'b0; tick(4);
    // R8
    chk("R8 set", rd_data[6], 1'b1);
    chk("R10 nmi chk", nmi_req, 1'b1);
    chan_chk_n = 1'b1; tick(4);
    chk("R8 sticky", rd_data[6], 1'b1);
    wr(8'h04);
    chk("R9 keep6", rd_data[6], 1'b1);
    wr(8'h0C);
    chk("R9 clr6", {rd_data[6], nmi_req}, 2'b00);
    chan_chk_n = 1'b0; tick(4);
    // R8 masked
    chk("R8 masked", {rd_data[6], nmi_req}, 2'b00);
    chan_chk_n = 1'b1; tick(4);

    wr(8'h00);
    bus_err = 1'b1; chan_chk_n = 1'b0; tick(4);
    chk("R7/R8 both", rd_data[7:6], 2'b11);
    bus_err = 1'b0; chan_chk_n = 1'b1; tick(4);
    wr(8'h04);
    // R9 only bit 7 cleared
    chk("R9 partial", rd_data[7:6], 2'b01);
    chk("R10 still", nmi_req, 1'b1);
    wr(8'h0C);
    chk("R9 both", rd_data, {2'b00, 1'b0, exp_tog, 4'hC});
    chk("R10 off", nmi_req, 1'b0);

    finish_run();
  end
endmodule